// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block carries out the subroutine-transfer instructions of a small microcontroller whose instructions are 16 bits wide. A start strobe hands it one instruction word, plus the following word when the instruction has two, along with the address of that instruction, the 16-bit Z pointer and the current status register. The block decodes the word and runs a fixed sequence. There are three call forms, a plain return and a return from interrupt.

A call writes the address of the next instruction, two bytes, into a stack that lives in byte-wide data memory and grows downward. It then delivers the call target. A return reads the two bytes back and delivers the recovered address. A return from interrupt also produces a status register write with the global interrupt enable bit set. The new program counter, the stack pointer and a one-cycle done pulse are registered outputs.

The stack memory port is meant for a synchronous block RAM that returns read data one cycle after the address is presented. Each instruction class takes a fixed number of cycles, whatever the operand values are.

Top module: `crs_top`

## Requirements
- R1: A word matching 1101 followed by a 12-bit offset (bits 11:0, two's complement) is a relative call. The new pc_out is (pc_in + 1 + offset) mod 2^PC_W, and done rises 3 cycles after the clock edge that accepts start.
- R2: A word with bits 15:9 = 1001010 and bits 3:1 = 111 is a two-word absolute call. The 22-bit target is {bits 8:4, bit 0, instr_ext}, reduced mod 2^PC_W. The pushed return address is pc_in + 2, and done rises 4 cycles after acceptance.
- R3: The word 1001 0101 xxxx 1001 is an indirect call. pc_out becomes z_in mod 2^PC_W, the return address is pc_in + 1, and done rises 3 cycles after acceptance.
- R4: A call stores the low byte of the return address at address SP and the high byte at SP-1, where SP is the stack pointer before the call. The stack pointer ends 2 lower, and each call does exactly two memory accesses.
- R5: The word 1001 0101 0xx0 1000 is a return. It reads the high byte from SP+1 and the low byte from SP+2, and pc_out becomes that 16-bit value mod 2^PC_W. The stack pointer ends 2 higher, and done rises 4 cycles after acceptance.
- R6: The word 1001 0101 0xx1 1000 is a return from interrupt. It behaves as R5, and in the done cycle status_we is high with status_wdata = status_in with bit 7 set. No other instruction raises status_we.
- R7: done is high for exactly one cycle, and no memory access is issued in that cycle. busy is high from the cycle after acceptance until done.
- R8: A start asserted while busy is ignored. It causes no extra done, and it does not change the results of the instruction in progress.
- R9: Any other word completes with done one cycle after acceptance. pc_out becomes pc_in + 1, there is no memory access, and the stack pointer is unchanged.
- R10: After reset, done, busy, mem_en and status_we are 0, pc_out is 0 and sp_out equals SP_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing the presented instruction |
| instr | input | 16 | Instruction word |
| instr_ext | input | 16 | Second word of a two-word instruction |
| pc_in | input | PC_W | Address of the presented instruction |
| z_in | input | 16 | Z pointer value for the indirect call |
| status_in | input | 8 | Current status register |
| mem_rdata | input | 8 | Stack memory read data, one cycle after the address |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | PC_W | New program counter, valid with done |
| sp_out | output | SP_W | Stack pointer |
| mem_en | output | 1 | Stack memory access enable |
| mem_we | output | 1 | Stack memory write enable |
| mem_addr | output | SP_W | Stack memory address |
| mem_wdata | output | 8 | Stack memory write data |
| status_we | output | 1 | Status register write strobe |
| status_wdata | output | 8 | Status register write value |

## Verification
Results fall due at a fixed offset from the accepting edge: done, pc_out and sp_out after 3 edges for the relative and indirect calls, after 4 for the absolute call and both returns, and after 1 for an unrecognised word. The status write lands in the same cycle as done for a return from interrupt. The driver stamps every expected item with its due cycle number. The monitor samples on the falling edge and compares both the arrival cycle and the values, so a sequence that finishes early or late fails even when its data are right. The stored stack bytes and the number of memory accesses are checked by the driver once each item has been retired.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RCALL,
    OP_CALL,
    OP_ICALL,
    OP_RET,
    OP_RETI
  } op_e;

  localparam int STEP_W = 2;

  // Index of the edge (counted from the accepting edge as 0) on which done is registered.
  function automatic logic [STEP_W-1:0] final_step(input op_e op);
    case (op)
      OP_RCALL, OP_ICALL:       return STEP_W'(2);
      OP_CALL, OP_RET, OP_RETI: return STEP_W'(3);
      default:                  return STEP_W'(0);
    endcase
  endfunction

  function automatic logic op_pushes(input op_e op);
    return (op == OP_RCALL) || (op == OP_CALL) || (op == OP_ICALL);
  endfunction

  function automatic logic op_pops(input op_e op);
    return (op == OP_RET) || (op == OP_RETI);
  endfunction

endpackage

// File: rtl/crs_decode.sv
module crs_decode
  import crs_pkg::*;
#(
  parameter int PC_W = 14
) (
  input  logic [15:0]     instr,
  input  logic [15:0]     instr_ext,
  input  logic [PC_W-1:0] pc,
  input  logic [15:0]     z,
  output op_e             op,
  output logic [PC_W-1:0] target,
  output logic [PC_W-1:0] ret_addr
);

  logic [PC_W-1:0] next_one;
  logic [PC_W-1:0] next_two;
  logic [31:0]     rel_off;
  logic [21:0]     abs_k;

  assign next_one = pc + PC_W'(1);
  assign next_two = pc + PC_W'(2);
  assign rel_off  = {{20{instr[11]}}, instr[11:0]};
  assign abs_k    = {instr[8:4], instr[0], instr_ext};

  always_comb begin
    casez (instr)
      16'b1101_????_????_????: op = OP_RCALL;
      16'b1001_010?_????_111?: op = OP_CALL;
      16'b1001_0101_????_1001: op = OP_ICALL;
      16'b1001_0101_0??0_1000: op = OP_RET;
      16'b1001_0101_0??1_1000: op = OP_RETI;
      default:                 op = OP_NONE;
    endcase
  end

  always_comb begin
    case (op)
      OP_RCALL: target = next_one + PC_W'(rel_off);
      OP_CALL:  target = PC_W'(abs_k);
      OP_ICALL: target = PC_W'(z);
      default:  target = next_one;
    endcase
  end

  assign ret_addr = (op == OP_CALL) ? next_two : next_one;

endmodule

// File: rtl/crs_timer.sv
module crs_timer
  import crs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [STEP_W-1:0] last,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              accept,
  output logic              fire
);

  logic [STEP_W-1:0] last_q;

  assign accept = start && !busy;
  assign fire   = busy ? (step == last_q) : (accept && (last == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      step   <= '0;
      last_q <= '0;
    end else if (accept && (last != '0)) begin
      busy   <= 1'b1;
      step   <= STEP_W'(1);
      last_q <= last;
    end else if (busy) begin
      if (step == last_q) busy <= 1'b0;
      else                step <= step + STEP_W'(1);
    end
  end

  // R7
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (step != '0) && (step <= last_q));

endmodule

// File: rtl/crs_stack.sv
module crs_stack
  import crs_pkg::*;
#(
  parameter int          PC_W    = 14,
  parameter int          SP_W    = 10,
  parameter logic [SP_W-1:0] SP_INIT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              do_push,
  input  logic              do_pop,
  input  logic              busy,
  input  logic [STEP_W-1:0] step,
  input  logic [PC_W-1:0]   ret_addr,
  input  logic [7:0]        mem_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [SP_W-1:0]   mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [SP_W-1:0]   sp,
  output logic [15:0]       popped
);

  logic        push_q;
  logic        pop_q;
  logic [15:0] ret_q;
  logic [7:0]  hi_q;
  logic [15:0] ret16;

  assign ret16  = 16'(ret_addr);
  assign popped = {hi_q, mem_rdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      sp        <= SP_INIT;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      push_q    <= 1'b0;
      pop_q     <= 1'b0;
      ret_q     <= '0;
      hi_q      <= '0;
    end else begin
      mem_en <= 1'b0;
      mem_we <= 1'b0;
      if (accept) begin
        push_q <= do_push;
        pop_q  <= do_pop;
        ret_q  <= ret16;
        if (do_push) begin
          mem_en    <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= sp;
          mem_wdata <= ret16[7:0];
          sp        <= sp - SP_W'(1);
        end else if (do_pop) begin
          mem_en   <= 1'b1;
          mem_addr <= sp + SP_W'(1);
          sp       <= sp + SP_W'(1);
        end
      end else if (busy) begin
        if (step == STEP_W'(1)) begin
          if (push_q) begin
            mem_en    <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= sp;
            mem_wdata <= ret_q[15:8];
            sp        <= sp - SP_W'(1);
          end else if (pop_q) begin
            mem_en   <= 1'b1;
            mem_addr <= sp + SP_W'(1);
            sp       <= sp + SP_W'(1);
          end
        end
        if (pop_q && (step == STEP_W'(2))) hi_q <= mem_rdata;
      end
    end
  end

  // R4
  push_sp_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |-> (sp == mem_addr - SP_W'(1)));

  // R5
  pop_sp_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |-> (sp == mem_addr));

endmodule

// File: rtl/crs_top.sv
module crs_top
  import crs_pkg::*;
#(
  parameter int              PC_W    = 14,
  parameter int              SP_W    = 10,
  parameter logic [SP_W-1:0] SP_INIT = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [15:0]     instr,
  input  logic [15:0]     instr_ext,
  input  logic [PC_W-1:0] pc_in,
  input  logic [15:0]     z_in,
  input  logic [7:0]      status_in,
  input  logic [7:0]      mem_rdata,
  output logic            busy,
  output logic            done,
  output logic [PC_W-1:0] pc_out,
  output logic [SP_W-1:0] sp_out,
  output logic            mem_en,
  output logic            mem_we,
  output logic [SP_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  output logic            status_we,
  output logic [7:0]      status_wdata
);

  localparam logic [7:0] GIE_MASK = 8'h80;

  op_e               dec_op;
  logic [PC_W-1:0]   dec_target;
  logic [PC_W-1:0]   dec_ret;
  logic [STEP_W-1:0] step;
  logic              accept;
  logic              fire;
  logic [15:0]       popped;
  op_e               op_q;
  logic [PC_W-1:0]   target_q;
  op_e               cur_op;
  logic [PC_W-1:0]   cur_target;

  crs_decode #(.PC_W(PC_W)) u_decode (
    .instr    (instr),
    .instr_ext(instr_ext),
    .pc       (pc_in),
    .z        (z_in),
    .op       (dec_op),
    .target   (dec_target),
    .ret_addr (dec_ret)
  );

  crs_timer u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .last  (final_step(dec_op)),
    .busy  (busy),
    .step  (step),
    .accept(accept),
    .fire  (fire)
  );

  crs_stack #(.PC_W(PC_W), .SP_W(SP_W), .SP_INIT(SP_INIT)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .do_push  (op_pushes(dec_op)),
    .do_pop   (op_pops(dec_op)),
    .busy     (busy),
    .step     (step),
    .ret_addr (dec_ret),
    .mem_rdata(mem_rdata),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .sp       (sp_out),
    .popped   (popped)
  );

  assign cur_op     = busy ? op_q : dec_op;
  assign cur_target = busy ? target_q : dec_target;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q         <= OP_NONE;
      target_q     <= '0;
      done         <= 1'b0;
      pc_out       <= '0;
      status_we    <= 1'b0;
      status_wdata <= '0;
    end else begin
      if (accept) begin
        op_q     <= dec_op;
        target_q <= dec_target;
      end
      done      <= fire;
      status_we <= fire && (cur_op == OP_RETI);
      if (fire) begin
        pc_out       <= op_pops(cur_op) ? PC_W'(popped) : cur_target;
        status_wdata <= status_in | GIE_MASK;
      end
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  quiet_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_en);

  // R6
  status_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    status_we |-> (done && status_wdata[7]));

  // R8
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(rst)) |-> $stable(op_q));

endmodule

// File: tb/crs_top_test.sv
`timescale 1ns/1ps
module crs_top_test;

  localparam int PC_W = 14;
  localparam int SP_W = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [15:0]     instr = '0;
  logic [15:0]     instr_ext = '0;
  logic [PC_W-1:0] pc_in = '0;
  logic [15:0]     z_in = '0;
  logic [7:0]      status_in = '0;
  logic [7:0]      mem_rdata;
  logic            busy, done, mem_en, mem_we, status_we;
  logic [PC_W-1:0] pc_out;
  logic [SP_W-1:0] sp_out, mem_addr;
  logic [7:0]      mem_wdata, status_wdata;

  always #10 clk = ~clk;

  crs_top uut (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .instr_ext(instr_ext),
    .pc_in(pc_in), .z_in(z_in), .status_in(status_in), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .status_we(status_we), .status_wdata(status_wdata)
  );

  logic [7:0] ram [0:(1<<SP_W)-1];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr];
    end
  end

  int cyc = 0;
  int acc_cnt = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_en) acc_cnt <= acc_cnt + 1;
  end

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    int         due;
    int         pc;
    int         sp;
    bit         reti;
    logic [7:0] stat;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   mstk[$];
  int   msp = 10'h3FF;

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (status_we && !done) chk(0, "R6", "status_we without done", 1, 0);
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cyc == e.due, e.req, "done cycle", cyc, e.due);
          chk(int'(pc_out) == e.pc, e.req, "pc_out", int'(pc_out), e.pc);
          chk(int'(sp_out) == e.sp, e.req, "sp_out", int'(sp_out), e.sp);
          chk(status_we == e.reti, "R6", "status_we", int'(status_we), int'(e.reti));
          if (e.reti) chk(status_wdata == e.stat, "R6", "status_wdata", status_wdata, e.stat);
        end
      end
    end
  end

  // kind: 0 none, 1 call, 2 return, 3 return from interrupt
  task automatic run_op(input logic [15:0] w, input logic [15:0] w2, input int pc,
                        input logic [15:0] z, input logic [7:0] st, input int kind,
                        input int lat, input int exp_pc, input int exp_ret,
                        input string req, input bit poke);
    exp_t e;
    int acc0;
    int old_sp;
    acc0   = acc_cnt;
    old_sp = msp;
    e.req  = req;
    e.reti = (kind == 3);
    e.stat = st | 8'h80;
    if (kind >= 2) begin
      e.pc = mstk.pop_back();
      msp  = (msp + 2) & 10'h3FF;
    end else begin
      e.pc = exp_pc;
      if (kind == 1) msp = (msp - 2) & 10'h3FF;
    end
    e.sp = msp;
    @(negedge clk);
    instr = w; instr_ext = w2; pc_in = PC_W'(pc); z_in = z; status_in = st;
    start = 1'b1;
    e.due = cyc + lat;
    exp_q.push_back(e);
    @(negedge clk);
    if (poke) begin
      instr = 16'h9509; z_in = 16'h0ABC;
      start = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    if (lat > 2) chk(busy == 1'b1, "R7", "busy during sequence", int'(busy), 1);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(acc_cnt - acc0 == ((kind == 0) ? 0 : 2), (kind == 0) ? "R9" : "R4",
        "memory accesses", acc_cnt - acc0, (kind == 0) ? 0 : 2);
    if (kind == 1) begin
      chk(ram[old_sp] == exp_ret[7:0], "R4", "low byte at SP", ram[old_sp], exp_ret & 8'hFF);
      chk(ram[(old_sp - 1) & 10'h3FF] == exp_ret[15:8], "R4", "high byte at SP-1",
          ram[(old_sp - 1) & 10'h3FF], (exp_ret >> 8) & 8'hFF);
      mstk.push_back(exp_ret);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(done == 0 && busy == 0 && mem_en == 0 && status_we == 0, "R10", "idle flags",
        {done, busy, mem_en, status_we}, 0);
    chk(pc_out == '0, "R10", "pc_out", pc_out, 0);
    chk(sp_out == 10'h3FF, "R10", "sp_out", sp_out, 10'h3FF);

    // R1 relative call forward
    run_op(16'hD010, 16'h0, 16'h0100, 16'h0, 8'h00, 1, 3, 16'h0111, 16'h0101, "R1", 0);
    // R5 return
    run_op(16'h9508, 16'h0, 16'h0000, 16'h0, 8'h00, 2, 4, 0, 0, "R5", 0);
    // R1 relative call backward with wrap below zero
    run_op(16'hDFF0, 16'h0, 16'h0005, 16'h0, 8'h00, 1, 3, 16'h3FF6, 16'h0006, "R1", 0);
    // R6 return from interrupt
    run_op(16'h9518, 16'h0, 16'h0000, 16'h0, 8'h05, 3, 4, 0, 0, "R6", 0);
    // R2 absolute call, target and return address both reduced
    run_op(16'h95FF, 16'h1234, 16'h3FFF, 16'h0, 8'h00, 1, 4, 16'h1234, 16'h0001, "R2", 0);
    // R3 indirect call nested
    run_op(16'h9509, 16'h0, 16'h0200, 16'hC321, 8'h00, 1, 3, 16'h0321, 16'h0201, "R3", 0);
    // R5 last in, first out
    run_op(16'h9568, 16'h0, 16'h0000, 16'h0, 8'h00, 2, 4, 0, 0, "R5", 0);
    run_op(16'h9508, 16'h0, 16'h0000, 16'h0, 8'h00, 2, 4, 0, 0, "R5", 0);
    // R9 unrecognised word
    run_op(16'h0000, 16'h0, 16'h0050, 16'h0, 8'h00, 0, 1, 16'h0051, 0, "R9", 0);
    // R8 start while busy is ignored
    run_op(16'hD7FF, 16'h0, 16'h1000, 16'h0, 8'h00, 1, 3, 16'h1800, 16'h1001, "R8", 1);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0 && busy == 0, "R8", "no second sequence", int'(busy), 0);
    // R6 variant encoding, upper status bits kept
    run_op(16'h9578, 16'h0, 16'h0000, 16'h0, 8'h42, 3, 4, 0, 0, "R6", 0);
    chk(sp_out == 10'h3FF, "R5", "stack balanced", sp_out, 10'h3FF);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule